// File: doc/BRIEF.md
# Still Image Pixel Transfer Port

This block is a single 32-bit host-visible word through which software moves RGB pixels, one at a time, between a host clock domain and a video clock domain. In compression mode the host writes a pixel; the block hands it across the clock boundary with a toggle request/acknowledge pair and presents it on the video output for one video-clock cycle. In decompression mode a pixel offered by the video side is captured, carried across the clock boundary and becomes readable by the host.

A busy flag inside the same word tells software when the next access may be made. The flag starts at 0 in compression mode and at 1 in decompression mode. An external layout-select input chooses one of two byte layouts, and the layout choice also moves the busy flag between the top byte and the bottom byte. Mode and layout are assumed to change only while no transfer is in flight.

Top module: `stillpx_port`

## Requirements
- R1: After reset the busy flag is 0 when `mode_decomp` is 0 and 1 when `mode_decomp` is 1.
- R2: In compression mode a host write made while busy is 0 sets busy to 1 on the next host cycle. The pixel then appears once on `vid_out_pix`, with `vid_out_valid` high for exactly one video cycle, and busy returns to 0 afterwards.
- R3: In compression mode a host write made while busy is 1 is ignored: the pending pixel is neither overwritten nor sent a second time.
- R4: In decompression mode host writes have no effect on the readable pixel and produce no video output.
- R5: In decompression mode, after the video side hands over a pixel, busy falls to 0 with that pixel readable. A host read (`rd_en`) made while busy is 0 sets busy back to 1 on the next host cycle.
- R6: With `order_sel` = 0 the busy flag is bit 31, red is bits 23:16, green is bits 15:8 and blue is bits 7:0. Bits 30:24 read as zero.
- R7: With `order_sel` = 1 the busy flag is bit 7, blue is bits 31:24, green is bits 23:16 and red is bits 15:8. Bits 6:0 read as zero.
- R8: A change of `mode_decomp` sets busy, on the next host cycle, to the reset value of the new mode.
- R9: `vid_in_ready` drops for the cycle after a pixel is accepted and stays low until the host has read that pixel; it then returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_h | input | 1 | Host clock |
| rst_h_n | input | 1 | Host-domain synchronous reset, active low |
| mode_decomp | input | 1 | 0 = compression (host to video), 1 = decompression (video to host) |
| order_sel | input | 1 | Byte layout select; also picks the busy flag position |
| wr_en | input | 1 | Host write strobe for the transfer word |
| wr_data | input | 32 | Host write data |
| rd_en | input | 1 | Host read strobe; consumes the pixel in decompression mode |
| rd_data | output | 32 | Transfer word as seen by the host: pixel plus busy flag |
| clk_v | input | 1 | Video clock |
| rst_v_n | input | 1 | Video-domain synchronous reset, active low |
| vid_out_valid | output | 1 | One-cycle strobe marking a pixel on vid_out_pix |
| vid_out_pix | output | 24 | Outgoing pixel {R,G,B} |
| vid_in_valid | input | 1 | Video side offers a pixel |
| vid_in_pix | input | 24 | Incoming pixel {R,G,B} |
| vid_in_ready | output | 1 | Port can take an incoming pixel |

## Verification
Compression is driven with distinct pixel values under both layouts, so a swapped channel or a wrongly placed flag shows up as a wrong video pixel or a wrong bit. A back-to-back second write tells a design that queues or overwrites apart from one that drops the write while busy. Decompression is run with pixels under both layouts and through a full accept, read and ready cycle, with a stray write in between. Mode flips in both directions, and resets with each mode held, separate the reset polarity of the flag from its re-initialisation on a mode change.

// File: rtl/stillpx_pkg.sv
// Shared types for the still pixel transfer port.
// Assumes: one pixel is three equal-width colour channels.
package stillpx_pkg;

    // Transfer direction, as given by the mode input.
    typedef enum logic {
        DIR_TO_VIDEO   = 1'b0,
        DIR_FROM_VIDEO = 1'b1
    } dir_e;

    // Host word layout; selects both channel placement and flag position.
    typedef enum logic {
        LAYOUT_FLAG_TOP = 1'b0,
        LAYOUT_FLAG_LOW = 1'b1
    } layout_e;

endpackage

// File: rtl/stillpx_tgl_rx.sv
// Receives a toggle signal from another clock domain.
// What it does: resynchronises the toggle through STAGES flops and emits a
// one-cycle pulse for every change of level.
// Assumes: the sender changes the toggle at most once per round trip, so
// no change is lost.
module stillpx_tgl_rx #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_in,
    output logic pulse
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Resynchroniser chain, one flop per stage.
    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= tgl_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    // Holds the previously seen level for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[STAGES-1];
    end

    assign pulse = sync_q[STAGES-1] ^ last_q;

    // A change pulse never lasts two cycles (supports R2, R5).
    assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

endmodule

// File: rtl/stillpx_fmt.sv
// Packs and unpacks the host transfer word.
// What it does: places the {R,G,B} pixel and the busy flag into the host word
// for the selected layout, and extracts a pixel from a written word.
// Assumes: the host word is four channels wide; purely combinational.
module stillpx_fmt
    import stillpx_pkg::*;
#(
    parameter int CH_W = 8
) (
    input  logic                 layout,
    input  logic                 busy,
    input  logic [3*CH_W-1:0]    pix_in,
    input  logic [4*CH_W-1:0]    word_in,
    output logic [4*CH_W-1:0]    word_out,
    output logic [3*CH_W-1:0]    pix_out
);
    logic [CH_W-1:0] r_in, g_in, b_in;
    logic [CH_W-1:0] flag_byte;

    assign {r_in, g_in, b_in} = pix_in;
    assign flag_byte = {busy, {(CH_W-1){1'b0}}};

    // Builds the readable word for the selected layout (R6, R7).
    always_comb begin
        if (layout_e'(layout) == LAYOUT_FLAG_TOP)
            word_out = {flag_byte, r_in, g_in, b_in};
        else
            word_out = {b_in, g_in, r_in, flag_byte};
    end

    // Extracts {R,G,B} from a written word for the selected layout (R6, R7).
    always_comb begin
        if (layout_e'(layout) == LAYOUT_FLAG_TOP)
            pix_out = word_in[3*CH_W-1:0];
        else
            pix_out = {word_in[2*CH_W-1:CH_W], word_in[3*CH_W-1:2*CH_W],
                       word_in[4*CH_W-1:3*CH_W]};
    end

endmodule

// File: rtl/stillpx_port.sv
// Still image pixel transfer port (top).
// What it does: one host word carries a pixel between host and video clock
// domains, in either direction, with a busy flag gating host access.
// Compression: host write -> toggle request -> video strobe -> toggle ack.
// Decompression: video accept -> toggle request -> host read -> toggle ack.
// Assumes: mode and layout change only while no transfer is in flight;
// each direction uses its own request/acknowledge toggle pair.
module stillpx_port
    import stillpx_pkg::*;
#(
    parameter int CH_W        = 8,
    parameter int SYNC_STAGES = 2,
    localparam int WORD_W     = 4 * CH_W,
    localparam int PIX_W      = 3 * CH_W
) (
    input  logic              clk_h,
    input  logic              rst_h_n,
    input  logic              mode_decomp,
    input  logic              order_sel,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    input  logic              clk_v,
    input  logic              rst_v_n,
    output logic              vid_out_valid,
    output logic [PIX_W-1:0]  vid_out_pix,
    input  logic              vid_in_valid,
    input  logic [PIX_W-1:0]  vid_in_pix,
    output logic              vid_in_ready
);
    // Host domain state.
    logic             busy_q;
    logic             mode_q;
    logic [PIX_W-1:0] pix_h;
    logic             creq_h;
    logic             dack_h;
    // Video domain state.
    logic             cack_v;
    logic             dreq_v;
    logic             pend_v;
    logic [PIX_W-1:0] hold_v;
    // Crossing pulses.
    logic             creq_seen_v, dack_seen_v;
    logic             cack_seen_h, dreq_seen_h;
    logic [PIX_W-1:0] wr_pix;
    logic             to_video, mode_flip, wr_take, rd_take;

    assign to_video  = (dir_e'(mode_decomp) == DIR_TO_VIDEO);
    assign mode_flip = (mode_decomp != mode_q);
    assign wr_take   = wr_en && !busy_q && to_video && !mode_flip;
    assign rd_take   = rd_en && !busy_q && !to_video && !mode_flip;

    stillpx_fmt #(.CH_W(CH_W)) u_fmt (
        .layout   (order_sel),
        .busy     (busy_q),
        .pix_in   (pix_h),
        .word_in  (wr_data),
        .word_out (rd_data),
        .pix_out  (wr_pix)
    );

    stillpx_tgl_rx #(.STAGES(SYNC_STAGES)) u_creq_rx (
        .clk(clk_v), .rst_n(rst_v_n), .tgl_in(creq_h), .pulse(creq_seen_v));
    stillpx_tgl_rx #(.STAGES(SYNC_STAGES)) u_dack_rx (
        .clk(clk_v), .rst_n(rst_v_n), .tgl_in(dack_h), .pulse(dack_seen_v));
    stillpx_tgl_rx #(.STAGES(SYNC_STAGES)) u_cack_rx (
        .clk(clk_h), .rst_n(rst_h_n), .tgl_in(cack_v), .pulse(cack_seen_h));
    stillpx_tgl_rx #(.STAGES(SYNC_STAGES)) u_dreq_rx (
        .clk(clk_h), .rst_n(rst_h_n), .tgl_in(dreq_v), .pulse(dreq_seen_h));

    // Tracks the mode last seen, to detect a mode change.
    always_ff @(posedge clk_h) begin
        if (!rst_h_n) mode_q <= mode_decomp;
        else          mode_q <= mode_decomp;
    end

    // Busy flag: mode reset value, then set/clear per direction (R1,R2,R5,R8).
    always_ff @(posedge clk_h) begin
        if (!rst_h_n)          busy_q <= mode_decomp;
        else if (mode_flip)    busy_q <= mode_decomp;
        else if (to_video) begin
            if (wr_take)          busy_q <= 1'b1;
            else if (cack_seen_h) busy_q <= 1'b0;
        end else begin
            if (dreq_seen_h)      busy_q <= 1'b0;
            else if (rd_take)     busy_q <= 1'b1;
        end
    end

    // Host pixel register: loaded by an accepted write or an arrived pixel (R3,R4).
    always_ff @(posedge clk_h) begin
        if (!rst_h_n)                                 pix_h <= '0;
        else if (wr_take)                             pix_h <= wr_pix;
        else if (!to_video && !mode_flip && dreq_seen_h) pix_h <= hold_v;
    end

    // Host-side toggles: request for outgoing pixels, ack for consumed ones.
    always_ff @(posedge clk_h) begin
        if (!rst_h_n) begin
            creq_h <= 1'b0;
            dack_h <= 1'b0;
        end else begin
            if (wr_take) creq_h <= ~creq_h;
            if (rd_take) dack_h <= ~dack_h;
        end
    end

    // Video output: one-cycle strobe per arrived request, then acknowledge (R2).
    always_ff @(posedge clk_v) begin
        if (!rst_v_n) begin
            vid_out_valid <= 1'b0;
            vid_out_pix   <= '0;
            cack_v        <= 1'b0;
        end else begin
            vid_out_valid <= creq_seen_v;
            if (creq_seen_v) begin
                vid_out_pix <= pix_h;
                cack_v      <= ~cack_v;
            end
        end
    end

    // Video input: accept one pixel, hold it until the host consumes it (R5,R9).
    always_ff @(posedge clk_v) begin
        if (!rst_v_n) begin
            pend_v <= 1'b0;
            hold_v <= '0;
            dreq_v <= 1'b0;
        end else if (vid_in_valid && !pend_v) begin
            pend_v <= 1'b1;
            hold_v <= vid_in_pix;
            dreq_v <= ~dreq_v;
        end else if (dack_seen_v) begin
            pend_v <= 1'b0;
        end
    end

    assign vid_in_ready = !pend_v;

    // Accepted compression write raises busy next cycle.
    assert_busy_on_write_R2: assert property (@(posedge clk_h) disable iff (!rst_h_n)
        (wr_en && !busy_q && !mode_decomp && !mode_flip) |=> busy_q);

    // Outgoing strobe lasts one video cycle.
    assert_out_strobe_R2: assert property (@(posedge clk_v) disable iff (!rst_v_n)
        vid_out_valid |=> !vid_out_valid);

    // Pending outgoing pixel is not overwritten while busy.
    assert_pending_kept_R3: assert property (@(posedge clk_h) disable iff (!rst_h_n)
        (busy_q && $past(busy_q) && !mode_decomp && !$past(mode_decomp) && !mode_flip)
        |-> $stable(pix_h));

    // Host read of an available pixel raises busy next cycle.
    assert_busy_on_read_R5: assert property (@(posedge clk_h) disable iff (!rst_h_n)
        (rd_en && !busy_q && mode_decomp && !mode_flip) |=> busy_q);

    // Mode change loads the new mode's reset value into busy.
    assert_mode_reinit_R8: assert property (@(posedge clk_h) disable iff (!rst_h_n)
        mode_flip |=> (busy_q == $past(mode_decomp)));

    // Ready drops after an accepted incoming pixel.
    assert_ready_drop_R9: assert property (@(posedge clk_v) disable iff (!rst_v_n)
        (vid_in_valid && vid_in_ready) |=> !vid_in_ready);

endmodule

// File: tb/stillpx_port_bench.sv
module stillpx_port_bench;
    logic        clk_h = 1'b0, clk_v = 1'b0;
    logic        rst_h_n, rst_v_n;
    logic        mode_decomp, order_sel, wr_en, rd_en;
    logic [31:0] wr_data, rd_data;
    logic        vid_out_valid, vid_in_valid, vid_in_ready;
    logic [23:0] vid_out_pix, vid_in_pix;

    int checks = 0, errors = 0;
    int pulse_cnt = 0;
    logic [23:0] last_out = '0;

    always #4 clk_h = ~clk_h;   // 125 MHz host clock
    always #3 clk_v = ~clk_v;   // video clock

    stillpx_port u_stillpx_port (
        .clk_h(clk_h), .rst_h_n(rst_h_n), .mode_decomp(mode_decomp),
        .order_sel(order_sel), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .clk_v(clk_v), .rst_v_n(rst_v_n),
        .vid_out_valid(vid_out_valid), .vid_out_pix(vid_out_pix),
        .vid_in_valid(vid_in_valid), .vid_in_pix(vid_in_pix),
        .vid_in_ready(vid_in_ready));

    // Counts outgoing strobes, sampled mid-cycle.
    always @(negedge clk_v) begin
        if (vid_out_valid) begin
            pulse_cnt = pulse_cnt + 1;
            last_out  = vid_out_pix;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic busy_bit();
        return order_sel ? rd_data[7] : rd_data[31];
    endfunction

    task automatic do_reset(input logic mode);
        mode_decomp = mode; order_sel = 1'b0; wr_en = 0; rd_en = 0;
        wr_data = '0; vid_in_valid = 0; vid_in_pix = '0;
        rst_h_n = 0; rst_v_n = 0;
        repeat (4) @(negedge clk_h);
        rst_h_n = 1; rst_v_n = 1;
        @(negedge clk_h);
    endtask

    task automatic wait_busy(input logic val);
        for (int i = 0; i < 100; i++) begin
            if (busy_bit() == val) break;
            @(negedge clk_h);
        end
    endtask

    task automatic host_write(input logic [31:0] d);
        wr_en = 1; wr_data = d;
        @(negedge clk_h);
        wr_en = 0;
    endtask

    task automatic host_read();
        rd_en = 1;
        @(negedge clk_h);
        rd_en = 0;
    endtask

    task automatic video_push(input logic [23:0] p);
        @(negedge clk_v);
        for (int i = 0; i < 100; i++) begin
            if (vid_in_ready) break;
            @(negedge clk_v);
        end
        vid_in_valid = 1; vid_in_pix = p;
        @(negedge clk_v);
        vid_in_valid = 0;
        check("R9 ready low after accept", {31'b0, vid_in_ready}, 32'd0);
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        check("R1 compress reset word", rd_data, 32'h0);
        order_sel = 1; #1;
        check("R1 compress busy low layout", {31'b0, busy_bit()}, 32'd0);
        do_reset(1'b1);
        check("R1 decompress reset busy", {31'b0, rd_data[31]}, 32'd1);
    endtask

    task automatic t_comp_top();
        int base;
        do_reset(1'b0);
        base = pulse_cnt;
        host_write(32'h00AABBCC);
        check("R2 busy set after write", {31'b0, rd_data[31]}, 32'd1);
        check("R6 readback layout top", rd_data, 32'h80AABBCC);
        wait_busy(1'b0);
        check("R2 busy clears", {31'b0, rd_data[31]}, 32'd0);
        check("R2 one strobe", pulse_cnt - base, 32'd1);
        check("R6 video pixel", {8'h0, last_out}, 32'h00AABBCC);
    endtask

    task automatic t_comp_low();
        int base;
        do_reset(1'b0);
        order_sel = 1;
        base = pulse_cnt;
        host_write(32'h33221100);
        check("R7 busy at bit7", rd_data, 32'h33221180);
        wait_busy(1'b0);
        check("R7 video pixel", {8'h0, last_out}, 32'h00112233);
        check("R2 one strobe low", pulse_cnt - base, 32'd1);
    endtask

    task automatic t_ignore_busy();
        int base;
        do_reset(1'b0);
        base = pulse_cnt;
        host_write(32'h00010203);
        host_write(32'h00F0E0D0);
        check("R3 pending pixel kept", rd_data, 32'h80010203);
        wait_busy(1'b0);
        repeat (10) @(negedge clk_h);
        check("R3 single strobe", pulse_cnt - base, 32'd1);
        check("R3 sent pixel", {8'h0, last_out}, 32'h00010203);
    endtask

    task automatic t_decomp();
        int base;
        do_reset(1'b0);
        mode_decomp = 1;
        @(negedge clk_h);
        check("R8 to decompress busy", {31'b0, rd_data[31]}, 32'd1);
        video_push(24'h123456);
        wait_busy(1'b0);
        check("R5 pixel readable", rd_data, 32'h00123456);
        base = pulse_cnt;
        host_write(32'h00999999);
        repeat (10) @(negedge clk_h);
        check("R4 write ignored", rd_data, 32'h00123456);
        check("R4 no strobe", pulse_cnt - base, 32'd0);
        check("R9 ready still low", {31'b0, vid_in_ready}, 32'd0);
        host_read();
        check("R5 busy after read", rd_data, 32'h80123456);
        repeat (10) @(negedge clk_h);
        check("R9 ready back", {31'b0, vid_in_ready}, 32'd1);
        order_sel = 1;
        video_push(24'hABCDEF);
        wait_busy(1'b0);
        check("R7 decompress layout", rd_data, 32'hEFCDAB00);
        host_read();
        check("R7 busy bit7 after read", rd_data, 32'hEFCDAB80);
        mode_decomp = 0;
        @(negedge clk_h);
        check("R8 to compress busy", {31'b0, busy_bit()}, 32'd0);
    endtask

    initial begin
        t_reset();
        t_comp_top();
        t_comp_low();
        t_ignore_busy();
        t_decomp();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk_h);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule